// File: doc/BRIEF.md
# Challenge Verifier and Response Builder

This block holds one byte buffer that a serial link engine fills with a 10-byte challenge and later reads back as a 47-byte answer. The engine writes bytes over a byte-addressed port while the block is idle and then pulses `start`. The block first exchanges two pairs of challenge bytes. It then runs a CRC-16 over the first eight bytes, one byte per clock, and compares the result with a check field held in the two top challenge bytes.

When the check matches, the block reads a 256-byte keystream table. The starting point is the AND of challenge bytes 0 and 7, and the table advances by one entry per byte, wrapping at 256. Each of the ten challenge bytes is XORed with its keystream byte. A fixed 37-byte trailer is then copied behind the challenge. When the check fails, the block sends back the exchanged challenge as it stands and leaves the upper buffer untouched. The keystream table and the trailer are parameters. A one-cycle `done` pulse tells the engine that the buffer may be read.

Top module: `cr_resp_builder`

## Requirements
- R1: After reset, `busy` and `done` are low and every one of the 47 buffer bytes reads as 0x00.
- R2: While idle, a write with `wr_en` high stores `wr_data` at `wr_addr` (0 to 46). `rd_data` shows the byte at `rd_addr` without a clock delay. Addresses 47 and above read as 0x00.
- R3: On `start`, bytes 2 and 8 trade places, and so do bytes 4 and 9. All later steps use this swapped buffer.
- R4: The CRC is CRC-16 with polynomial 0x1021, initial value 0x0000, no reflection and no final XOR, taken over swapped bytes 0 to 7 in order. It passes when it equals byte 9 (high) joined with byte 8 (low).
- R5: On a pass, swapped byte i (0 to 9) becomes itself XOR KEY[(b0 AND b7 + i) mod 256]. KEY[n] sits at bits [8n+7:8n] of the key parameter, and b0 and b7 are the swapped bytes 0 and 7.
- R6: On a pass, byte 10+j (j = 0 to 36) becomes trailer byte j, which sits at bits [8j+7:8j] of the trailer parameter.
- R7: On a fail, bytes 0 to 9 hold the swapped challenge and bytes 10 to 46 keep their earlier values.
- R8: `done` is a one-cycle pulse. Counting from the clock edge that samples `start`, it goes high after edge 57 on a pass and after edge 9 on a fail. `busy` is high from the edge after `start` through the `done` cycle.
- R9: A `start` that arrives while `busy` is high has no effect: the run ends as if it were absent, and no second run follows.
- R10: A buffer write attempted while `busy` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing the buffered challenge |
| busy | output | 1 | Processing in progress |
| done | output | 1 | One-cycle pulse when the buffer is ready |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 6 | Buffer write byte address |
| wr_data | input | 8 | Buffer write byte |
| rd_addr | input | 6 | Buffer read byte address |
| rd_data | output | 8 | Buffer byte at `rd_addr` |

## Verification
The in-RTL properties check the control flow on every cycle. `done` is a single pulse. A failed check goes straight to `done`, and a pass never does. A running job cannot be dropped or restarted by `start`. The keystream index steps by one each XOR cycle, and the CRC register clears when a job starts. The actual buffer contents can only be shown by the bench's scenarios, which compare them with a bit-serial CRC and an independent model of the swap, XOR and trailer. These scenarios cover an all-zero challenge, a keystream index that wraps past 255, one-bit check-field errors, and stray writes and starts during a run.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int CH_LEN    = 10;
  localparam int CRC_SPAN  = 8;
  localparam int TRAIL_LEN = 37;
  localparam int KEY_DEPTH = 256;
  localparam int BUF_LEN   = CH_LEN + TRAIL_LEN;
  localparam int AW        = $clog2(BUF_LEN);

  typedef enum logic [2:0] {
    S_IDLE, S_CRC, S_CHK, S_PRIME, S_XOR, S_TRAIL, S_DONE
  } st_t;

  // byte-wise CCITT update (poly 0x1021), shift-and-fold form
  function automatic logic [15:0] crc_byte_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] t;
    t = {c[7:0], c[15:8]};
    t = t ^ {8'h00, d};
    t = t ^ {12'h000, t[7:4]};
    t = t ^ {t[3:0], 12'h000};
    t = t ^ {3'b000, t[7:0], 5'b00000};
    return t;
  endfunction

  function automatic logic [8*KEY_DEPTH-1:0] default_key();
    logic [8*KEY_DEPTH-1:0] k;
    for (int i = 0; i < KEY_DEPTH; i++) k[8*i +: 8] = 8'(i * 29 + 17) ^ 8'(i >> 2);
    return k;
  endfunction

  function automatic logic [8*TRAIL_LEN-1:0] default_trailer();
    logic [8*TRAIL_LEN-1:0] t;
    for (int i = 0; i < TRAIL_LEN; i++) t[8*i +: 8] = 8'(i * 13 + 91);
    return t;
  endfunction
endpackage

// File: rtl/cr_crc_acc.sv
module cr_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 16'h0000;
    else if (clr) crc <= 16'h0000;
    else if (en)  crc <= cr_pkg::crc_byte_step(crc, din);
  end

  // R4
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 16'h0000));
endmodule

// File: rtl/cr_key_rom.sv
module cr_key_rom #(
  parameter int DEPTH = 256,
  parameter logic [8*DEPTH-1:0] CONTENT = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [$clog2(DEPTH)-1:0] addr,
  output logic [7:0]               q
);
  logic [7:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = CONTENT[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 8'h00;
    else if (en)  q <= tbl[addr];
  end
endmodule

// File: rtl/cr_resp_builder.sv
module cr_resp_builder #(
  parameter logic [8*cr_pkg::KEY_DEPTH-1:0] KEY_ROM = cr_pkg::default_key(),
  parameter logic [8*cr_pkg::TRAIL_LEN-1:0] TRAILER = cr_pkg::default_trailer()
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic                  wr_en,
  input  logic [cr_pkg::AW-1:0] wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [cr_pkg::AW-1:0] rd_addr,
  output logic [7:0]            rd_data
);
  import cr_pkg::*;
  localparam int KW = $clog2(KEY_DEPTH);

  st_t           st_q;
  logic [AW-1:0] pos_q;
  logic [KW-1:0] key_idx_q;
  logic [7:0]    mem_q [BUF_LEN];
  logic [7:0]    trail_byte [TRAIL_LEN];
  logic [15:0]   crc_w;
  logic [7:0]    rom_q;
  logic [AW-1:0] trail_sel_w;

  // named internal events
  logic job_go_w, crc_pass_w, host_wr_w, rom_en_w;
  assign job_go_w    = (st_q == S_IDLE) && start;
  assign crc_pass_w  = (crc_w == {mem_q[9], mem_q[8]});
  assign host_wr_w   = (st_q == S_IDLE) && !start && wr_en && (wr_addr < AW'(BUF_LEN));
  assign rom_en_w    = (st_q == S_PRIME) || (st_q == S_XOR);
  assign trail_sel_w = pos_q - AW'(CH_LEN);

  for (genvar g = 0; g < TRAIL_LEN; g++) begin : g_trail
    assign trail_byte[g] = TRAILER[8*g +: 8];
  end

  cr_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(job_go_w), .en(st_q == S_CRC),
    .din(mem_q[pos_q]), .crc(crc_w)
  );

  cr_key_rom #(.DEPTH(KEY_DEPTH), .CONTENT(KEY_ROM)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(rom_en_w), .addr(key_idx_q), .q(rom_q)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      pos_q     <= '0;
      key_idx_q <= '0;
    end else begin
      case (st_q)
        S_IDLE:  if (start) begin st_q <= S_CRC; pos_q <= '0; end
        S_CRC: begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == AW'(CRC_SPAN - 1)) st_q <= S_CHK;
        end
        S_CHK: begin
          if (crc_pass_w) begin
            key_idx_q <= mem_q[0] & mem_q[7];
            st_q      <= S_PRIME;
          end else begin
            st_q <= S_DONE;
          end
        end
        S_PRIME: begin
          key_idx_q <= key_idx_q + 1'b1;
          pos_q     <= '0;
          st_q      <= S_XOR;
        end
        S_XOR: begin
          key_idx_q <= key_idx_q + 1'b1;
          pos_q     <= pos_q + 1'b1;
          if (pos_q == AW'(CH_LEN - 1)) st_q <= S_TRAIL;
        end
        S_TRAIL: begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == AW'(BUF_LEN - 1)) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_LEN; i++) mem_q[i] <= 8'h00;
    end else if (job_go_w) begin
      mem_q[2] <= mem_q[8];
      mem_q[8] <= mem_q[2];
      mem_q[4] <= mem_q[9];
      mem_q[9] <= mem_q[4];
    end else if (host_wr_w) begin
      mem_q[wr_addr] <= wr_data;
    end else if (st_q == S_XOR) begin
      mem_q[pos_q] <= mem_q[pos_q] ^ rom_q;
    end else if (st_q == S_TRAIL) begin
      mem_q[pos_q] <= trail_byte[trail_sel_w];
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_DONE);
  assign rd_data = (rd_addr < AW'(BUF_LEN)) ? mem_q[rd_addr] : 8'h00;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  fail_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHK && !crc_pass_w) |=> done);

  // R5
  pass_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHK && crc_pass_w) |=> (busy && !done));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5
  key_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XOR) |-> (key_idx_q == $past(key_idx_q) + 1'b1));
endmodule

// File: tb/cr_resp_builder_tb_top.sv
module cr_resp_builder_tb_top;
  localparam int NB = 47;

  function automatic logic [7:0] tb_key(input int i);
    return 8'((i * 53) ^ 8'h3C ^ (i >> 5));
  endfunction
  function automatic logic [7:0] tb_trail(input int j);
    return 8'(j * 11 + 8'hA5);
  endfunction
  function automatic logic [2047:0] build_key();
    logic [2047:0] v;
    for (int i = 0; i < 256; i++) v[8*i +: 8] = tb_key(i);
    return v;
  endfunction
  function automatic logic [295:0] build_trail();
    logic [295:0] v;
    for (int j = 0; j < 37; j++) v[8*j +: 8] = tb_trail(j);
    return v;
  endfunction
  // bit-serial CCITT reference
  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  localparam logic [2047:0] TB_KEY   = build_key();
  localparam logic [295:0]  TB_TRAIL = build_trail();

  logic clk = 0, rst_n = 0, start = 0, wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic busy, done;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] s_arr [NB];
  logic [7:0] raw [NB];
  logic [7:0] expv [NB];

  always #5 clk = ~clk;

  cr_resp_builder #(.KEY_ROM(TB_KEY), .TRAILER(TB_TRAIL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] v);
    rd_addr = 6'(a);
    #1;
    v = rd_data;
  endtask

  // s_arr[0..7] prepared by caller
  task automatic run_trial(input bit want_pass, input bit disturb, input string name);
    logic [15:0] c;
    logic [7:0] v;
    int n, bad_lo, bad_hi, bad_rb;
    bit got;
    c = 16'h0000;
    for (int i = 0; i < 8; i++) c = crc_bits(c, s_arr[i]);
    s_arr[8] = c[7:0];
    s_arr[9] = c[15:8];
    if (!want_pass) s_arr[8] = s_arr[8] ^ 8'(1 << ($urandom % 8));
    for (int i = 0; i < 10; i++) raw[i] = s_arr[i];
    raw[2] = s_arr[8]; raw[8] = s_arr[2];
    raw[4] = s_arr[9]; raw[9] = s_arr[4];
    for (int i = 10; i < NB; i++) raw[i] = 8'($urandom);
    for (int i = 0; i < NB; i++) wr_byte(i, raw[i]);
    bad_rb = 0;
    for (int i = 0; i < NB; i++) begin rd_byte(i, v); if (v != raw[i]) bad_rb++; end
    // R2 readback
    check(bad_rb == 0, {"R2 readback ", name}, bad_rb, 0);
    // expected result
    for (int i = 0; i < NB; i++) expv[i] = (i < 10) ? s_arr[i] : raw[i];
    if (want_pass) begin
      for (int i = 0; i < 10; i++) expv[i] = s_arr[i] ^ tb_key(((s_arr[0] & s_arr[7]) + i) % 256);
      for (int j = 0; j < 37; j++) expv[10 + j] = tb_trail(j);
    end
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    n = 0; got = 0;
    while (!got && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) check(busy === 1'b1, {"R8 busy after start ", name}, busy, 1);
      if (done) got = 1;
      if (disturb) begin
        if (n == 3 || n == 20) begin
          start = 1; wr_en = 1; wr_addr = 6'd0; wr_data = ~raw[0];
        end else begin
          start = 0; wr_en = 0;
        end
      end
    end
    start = 0; wr_en = 0;
    // R8 latency
    check(got && n == (want_pass ? 57 : 9), {"R8 done latency ", name}, n, want_pass ? 57 : 9);
    repeat (3) @(negedge clk);
    // R9 no restart after a stray start
    check(!busy && !done, {"R9 idle after run ", name}, {busy, done}, 0);
    bad_lo = 0; bad_hi = 0;
    for (int i = 0; i < NB; i++) begin
      rd_byte(i, v);
      if (v != expv[i]) begin
        if (i < 10) bad_lo++; else bad_hi++;
        if (bad_lo + bad_hi == 1) $display("  %s byte %0d got %0h want %0h", name, i, v, expv[i]);
      end
    end
    // R3 R4 R5 R7 R10 challenge part, R6 R7 trailer part
    check(bad_lo == 0, {want_pass ? "R5 R3 R10 xor bytes " : "R7 R3 R4 swapped bytes ", name}, bad_lo, 0);
    check(bad_hi == 0, {want_pass ? "R6 trailer " : "R7 upper kept ", name}, bad_hi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!busy && !done, "R1 control after reset", {busy, done}, 0);
    bad = 0;
    for (int i = 0; i < NB; i++) begin rd_byte(i, v); if (v != 8'h00) bad++; end
    check(bad == 0, "R1 buffer zero after reset", bad, 0);
    wr_byte(50, 8'h77);
    rd_byte(50, v);
    // R2 out of range
    check(v == 8'h00, "R2 out-of-range read", v, 0);

    // directed: all-zero challenge passes with index 0
    for (int i = 0; i < 8; i++) s_arr[i] = 8'h00;
    run_trial(1'b1, 1'b0, "zero");
    // directed: index wraps past 255
    for (int i = 0; i < 8; i++) s_arr[i] = 8'($urandom);
    s_arr[0] = 8'hFF; s_arr[7] = 8'hFB;
    run_trial(1'b1, 1'b0, "wrap");
    // directed: single-bit check field error
    for (int i = 0; i < 8; i++) s_arr[i] = 8'($urandom);
    run_trial(1'b0, 1'b0, "crcbit");
    // stray start and write during runs
    for (int i = 0; i < 8; i++) s_arr[i] = 8'($urandom);
    run_trial(1'b1, 1'b1, "disturb_pass");
    for (int i = 0; i < 8; i++) s_arr[i] = 8'($urandom);
    run_trial(1'b0, 1'b1, "disturb_fail");
    // constrained random
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < 8; i++) s_arr[i] = 8'($urandom);
      run_trial(($urandom % 2) == 0, ($urandom % 3) == 0, $sformatf("rand%0d", t));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule